// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block sits behind the serial slave of a byte-wide EEPROM. It takes the word address and data bytes that the slave accepts during a write transaction and holds them in a page buffer. Each byte has its own valid flag. A stop condition starts a self-timed write cycle. When the timer expires, only the buffered bytes are written into the memory array.

While the cycle runs, the block raises `busy`. The slave uses this flag to stay off the bus, and this block ignores every input during the cycle. Incoming bytes wrap inside the current page rather than moving on to the next page. A write-protect input can block writes to the whole array or to its upper half, as a parameter selects. The block also keeps the word address counter that the slave shares with reads.

The slave reports one event per cycle. If it reports more than one, the block serves them in this order: start, then stop, then word address, then data byte.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy` is low, `memWe` is low and `curAddr` is zero.
- R2: A stop is accepted when at least one byte is buffered and the page is not protected. In the cycle after an accepted stop, `busy` rises. It stays high for exactly `WR_CYCLES + 2**PAGE_W` cycles, and the array is not written before the timed interval ends.
- R3: A word address pulse sets the row (the upper `ADDR_W-PAGE_W` bits) and the in-page offset (the low `PAGE_W` bits). After each data byte, only the offset increments, modulo `2**PAGE_W`. The byte that follows the last location of a page therefore lands on the first location of the same page.
- R4: If more bytes than a page holds are sent in one transaction, the byte received last for a location is the one that is written.
- R5: Only locations that received a byte are changed. Every other location in the array keeps its contents.
- R6: A stop with no buffered byte, or a start before the stop, discards the buffer. Neither raises `busy` nor writes the array.
- R7: While `busy` is high, start, stop, address and byte inputs have no effect on the array, on `curAddr` or on the next transaction.
- R8: `wpIn` is sampled at the stop. With `PROT_MODE`=2 and `wpIn` high, a page whose address MSB is 1 is not written and `busy` stays low. Pages whose address MSB is 0 are written normally. With `PROT_MODE`=1 and `wpIn` high, no page is written. With `wpIn` low, or with `PROT_MODE`=0, writes proceed.
- R9: A word address pulse loads `curAddr` with the address. When a commit ends, `curAddr` holds the last written address plus one, wrapped within the page.
- R10: `memWe` is asserted only while `busy` is high, and all the writes of one commit fall in one page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startSeen | input | 1 | Pulse: a start condition was seen on the bus |
| stopSeen | input | 1 | Pulse: a stop condition was seen on the bus |
| addrValid | input | 1 | Pulse: a word address was received |
| addrIn | input | ADDR_W | Word address |
| byteValid | input | 1 | Pulse: a data byte was received |
| byteData | input | 8 | Data byte |
| wpIn | input | 1 | Write-protect input |
| busy | output | 1 | High during the timed write cycle; the slave stays off the bus |
| memWe | output | 1 | Array write enable |
| memAddr | output | ADDR_W | Array write address |
| memData | output | 8 | Array write data |
| curAddr | output | ADDR_W | Shared word address counter |

## Verification
The assertions check on every cycle that array writes happen only while `busy` is high and stay within one page. They also check that `busy` rises only after a stop, that `curAddr` holds still through the cycle, and that full-array protection never lets a cycle start. The bench's scenarios cover the rest by comparing against a behavioural model on every clock and then comparing the whole array. Those scenarios show in-page wrap, overwrite when a page overflows, partial-page writes, discarded transactions, inputs ignored while busy, and upper-half protection.

// File: rtl/pagewr_pkg.sv
package pagewr_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clrBuf;
    logic loadAddr;
    logic storeByte;
    logic scanRst;
    logic scanStep;
    logic commit;
    logic finish;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_COMMIT = 2'd2
  } wr_state_e;
endpackage

// File: rtl/pagewr_ctrl.sv
module pagewr_ctrl
  import pagewr_pkg::*;
#(
  parameter int WR_CYCLES = 20
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  startSeen,
  input  logic  stopSeen,
  input  logic  addrValid,
  input  logic  byteValid,
  input  logic  anyValid,
  input  logic  pageLocked,
  input  logic  scanLast,
  output ctrl_t ctl,
  output logic  busy
);
  localparam int TMR_W = $clog2(WR_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WR_CYCLES - 1);

  wr_state_e state, stateNxt;
  logic [TMR_W-1:0] tmr;

  always_comb begin
    ctl = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (startSeen) begin
          ctl.clrBuf = 1'b1;
        end else if (stopSeen) begin
          if (anyValid && !pageLocked) stateNxt = ST_WAIT;
          else ctl.clrBuf = 1'b1;
        end else if (addrValid) begin
          ctl.loadAddr = 1'b1;
        end else if (byteValid) begin
          ctl.storeByte = 1'b1;
        end
      end
      ST_WAIT: begin
        if (tmr == TMR_LAST) begin
          stateNxt = ST_COMMIT;
          ctl.scanRst = 1'b1;
        end
      end
      ST_COMMIT: begin
        ctl.commit = 1'b1;
        ctl.scanStep = 1'b1;
        if (scanLast) begin
          ctl.finish = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tmr <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_WAIT) tmr <= tmr + 1'b1;
      else tmr <= '0;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pagewr_datapath.sv
module pagewr_datapath
  import pagewr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int PROT_MODE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        byteData,
  input  logic              wpIn,
  output logic              anyValid,
  output logic              pageLocked,
  output logic              scanLast,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic [ROW_W-1:0]  rowReg;
  logic [PAGE_W-1:0] ptr;
  logic [PAGE_W-1:0] idx;
  logic [PAGE-1:0]   vld;
  logic [7:0]        slotData [PAGE];

  // one slot per page byte
  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld[g] <= 1'b0;
        slotData[g] <= '0;
      end else if (ctl.clrBuf || ctl.finish) begin
        vld[g] <= 1'b0;
      end else if (ctl.storeByte && ptr == PAGE_W'(g)) begin
        vld[g] <= 1'b1;
        slotData[g] <= byteData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg <= '0;
      ptr <= '0;
      idx <= '0;
      curAddr <= '0;
    end else begin
      if (ctl.loadAddr) begin
        rowReg <= addrIn[ADDR_W-1:PAGE_W];
        ptr <= addrIn[PAGE_W-1:0];
        curAddr <= addrIn;
      end else if (ctl.storeByte) begin
        ptr <= ptr + 1'b1;
      end
      if (ctl.scanRst) idx <= '0;
      else if (ctl.scanStep) idx <= idx + 1'b1;
      if (ctl.finish) curAddr <= {rowReg, ptr};
    end
  end

  if (PROT_MODE == 1) begin : g_protAll
    assign pageLocked = wpIn;
  end else if (PROT_MODE == 2) begin : g_protUpper
    assign pageLocked = wpIn & rowReg[ROW_W-1];
  end else begin : g_protNone
    assign pageLocked = 1'b0;
  end

  assign anyValid = |vld;
  assign scanLast = &idx;
  assign memWe    = ctl.commit & vld[idx];
  assign memAddr  = {rowReg, idx};
  assign memData  = slotData[idx];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import pagewr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 20,
  parameter int PROT_MODE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              wpIn,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [ADDR_W-1:0] curAddr
);
  ctrl_t ctl;
  logic anyValid, pageLocked, scanLast;

  pagewr_ctrl #(.WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .addrValid(addrValid), .byteValid(byteValid), .anyValid(anyValid),
    .pageLocked(pageLocked), .scanLast(scanLast), .ctl(ctl), .busy(busy)
  );

  pagewr_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROT_MODE(PROT_MODE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrIn(addrIn), .byteData(byteData),
    .wpIn(wpIn), .anyValid(anyValid), .pageLocked(pageLocked), .scanLast(scanLast),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .curAddr(curAddr)
  );
endmodule

// File: rtl/pagewr_chk.sv
module pagewr_chk #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int PROT_MODE = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopSeen,
  input logic              wpIn,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] curAddr
);
  // R10
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R10
  one_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr[ADDR_W-1:PAGE_W] == $past(memAddr[ADDR_W-1:PAGE_W])));

  // R2
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopSeen));

  // R7
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(curAddr));

  // R8
  full_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !($past(wpIn) && PROT_MODE == 1));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |-> (!busy && !memWe));
endmodule

bind eeprom_page_writer pagewr_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROT_MODE(PROT_MODE)
) u_chk (
  .clk(clk), .rstN(rstN), .stopSeen(stopSeen), .wpIn(wpIn), .busy(busy),
  .memWe(memWe), .memAddr(memAddr), .curAddr(curAddr)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int ADDR_W = 8;
  localparam int PAGE_W = 3;
  localparam int WR_CYCLES = 20;
  localparam int PROT_MODE = 2;
  localparam int PAGE = 1 << PAGE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startSeen = 0, stopSeen = 0, addrValid = 0, byteValid = 0, wpIn = 0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [7:0] byteData = '0;
  logic busy, memWe;
  logic [ADDR_W-1:0] memAddr, curAddr;
  logic [7:0] memData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES),
                       .PROT_MODE(PROT_MODE)) u_dut (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .addrValid(addrValid), .addrIn(addrIn), .byteValid(byteValid),
    .byteData(byteData), .wpIn(wpIn), .busy(busy), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .curAddr(curAddr)
  );

  // array written through the DUT's write port
  logic [7:0] arr [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) arr[i] = 8'h00;
  always @(posedge clk) if (memWe) arr[memAddr] <= memData;

  // behavioural reference model
  int refArr [DEPTH];
  int pend [int];
  int busyLeft = 0;
  int mRow = 0, mPtr = 0, mCur = 0;
  initial for (int i = 0; i < DEPTH; i++) refArr[i] = 0;

  function automatic bit locked(bit wp, int row);
    if (!wp) return 0;
    if (PROT_MODE == 1) return 1;
    if (PROT_MODE == 2) return row >= (DEPTH / PAGE) / 2;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      if (busyLeft > 0) begin
        busyLeft--;
        if (busyLeft == 0) begin
          foreach (pend[a]) refArr[a] = pend[a];
          pend.delete();
          mCur = mRow * PAGE + mPtr;
        end
      end else if (startSeen) begin
        pend.delete();
      end else if (stopSeen) begin
        if (pend.num() > 0 && !locked(wpIn, mRow)) busyLeft = WR_CYCLES + PAGE;
        else pend.delete();
      end else if (addrValid) begin
        mRow = int'(addrIn) / PAGE;
        mPtr = int'(addrIn) % PAGE;
        mCur = int'(addrIn);
      end else if (byteValid) begin
        pend[mRow * PAGE + mPtr] = int'(byteData);
        mPtr = (mPtr + 1) % PAGE;
      end
      #1;
      check("R2 busy", int'(busy), int'(busyLeft > 0));
      check("R9 curAddr", int'(curAddr), mCur);
      if (memWe && !busy) check("R10 memWe outside busy", 1, 0);
    end
  end

  task automatic pulseStart();
    @(negedge clk) startSeen = 1; @(negedge clk) startSeen = 0;
  endtask
  task automatic pulseStop();
    @(negedge clk) stopSeen = 1; @(negedge clk) stopSeen = 0;
  endtask
  task automatic sendAddr(int a);
    @(negedge clk) begin addrValid = 1; addrIn = ADDR_W'(a); end
    @(negedge clk) addrValid = 0;
  endtask
  task automatic sendByte(int d);
    @(negedge clk) begin byteValid = 1; byteData = 8'(d); end
    @(negedge clk) byteValid = 0;
  endtask
  task automatic waitCycle();
    repeat (WR_CYCLES + PAGE + 4) @(negedge clk);
  endtask
  task automatic checkArray(string req);
    int bad = -1;
    for (int i = 0; i < DEPTH; i++) if (bad < 0 && int'(arr[i]) != refArr[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s array[%0h] actual=%0h expected=%0h", req, bad, arr[bad], refArr[bad]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 memWe", int'(memWe), 0);
    check("R1 curAddr", int'(curAddr), 0);
    rstN = 1;
    @(negedge clk);

    // R5 partial page write
    pulseStart(); sendAddr(8'h10); sendByte(8'hA1); sendByte(8'hA2); sendByte(8'hA3);
    pulseStop();
    // R2 nothing written before the interval ends
    repeat (5) @(negedge clk);
    check("R2 early array", int'(arr[8'h10]), 0);
    check("R2 busy high", int'(busy), 1);
    waitCycle();
    checkArray("R5 partial");
    check("R5 byte", int'(arr[8'h12]), 8'hA3);
    check("R9 curAddr", int'(curAddr), 8'h13);

    // R3 wrap within page
    pulseStart(); sendAddr(8'h1E);
    for (int i = 0; i < 4; i++) sendByte(8'hB0 + i);
    pulseStop(); waitCycle();
    checkArray("R3 wrap");
    check("R3 wrapped byte", int'(arr[8'h18]), 8'hB2);
    check("R3 next page untouched", int'(arr[8'h20]), 0);
    check("R9 wrapped curAddr", int'(curAddr), 8'h1A);

    // R4 overflow overwrites
    pulseStart(); sendAddr(8'h20);
    for (int i = 0; i < PAGE + 2; i++) sendByte(8'hC0 + i);
    pulseStop(); waitCycle();
    checkArray("R4 overflow");
    check("R4 last wins", int'(arr[8'h21]), 8'hC9);

    // R6 stop without data
    pulseStart(); sendAddr(8'h30); pulseStop();
    @(negedge clk);
    check("R6 no busy", int'(busy), 0);
    // R6 start before stop discards
    pulseStart(); sendAddr(8'h30); sendByte(8'h55); pulseStart(); pulseStop();
    @(negedge clk);
    check("R6 discard busy", int'(busy), 0);
    waitCycle();
    checkArray("R6 discard");
    check("R6 location", int'(arr[8'h30]), 0);

    // R7 inputs ignored while busy
    pulseStart(); sendAddr(8'h40); sendByte(8'hD1); pulseStop();
    pulseStart(); sendAddr(8'h48); sendByte(8'hEE); pulseStop();
    waitCycle();
    checkArray("R7 ignored");
    check("R7 ignored byte", int'(arr[8'h48]), 0);
    check("R7 curAddr", int'(curAddr), 8'h41);
    pulseStart(); sendByte(8'hD2); pulseStop(); waitCycle();
    check("R7 pointer kept", int'(arr[8'h41]), 8'hD2);

    // R8 upper half protected with wpIn high
    wpIn = 1;
    pulseStart(); sendAddr(8'h80); sendByte(8'h77); pulseStop();
    @(negedge clk);
    check("R8 locked no busy", int'(busy), 0);
    waitCycle();
    check("R8 locked array", int'(arr[8'h80]), 0);
    pulseStart(); sendAddr(8'h50); sendByte(8'h66); pulseStop(); waitCycle();
    check("R8 lower half", int'(arr[8'h50]), 8'h66);
    wpIn = 0;
    pulseStart(); sendAddr(8'h80); sendByte(8'h78); pulseStop(); waitCycle();
    check("R8 unlocked", int'(arr[8'h80]), 8'h78);
    checkArray("R8 final");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule